// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter is loaded from a programmable reload value. It counts down by one on each selected tick, and on the tick after it reaches zero it loads the reload value again. The period is therefore the reload value plus one tick. Each step from one to zero sets a sticky wrap flag. If interrupts are enabled, that step also produces a single-cycle interrupt request.

Software reaches the block through a simple word-aligned register bus with three registers: control/status at byte offset 0x10, reload at 0x14 and current count at 0x18. Reads return data in the same cycle. A read of control/status clears the wrap flag. A write of any data to the current-count register clears both the counter and the flag. The tick can come from the core clock or from an external reference enable.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-count registers all read 0 and `tick_irq` is low.
- R2: Registers sit at byte offsets 0x10 (control/status), 0x14 (reload) and 0x18 (current count). Address bits [1:0] are ignored, and any other offset reads 0 and writes nothing. Control bit 0 is run enable, bit 1 is interrupt enable, bit 2 is tick source and bit 16 is the wrap flag.
- R3: The reload and current-count registers hold bits [23:0] only. Bits [31:24] read as 0, and write data in those bits is dropped.
- R4: When run enable is 1 and tick source is 1, the counter advances on every clock. A count of zero loads the reload value, and any other count decrements, so a nonzero reload N gives one wrap every N+1 clocks.
- R5: When run enable is 1 and tick source is 0, the counter advances only on clocks where `ref_tick` is high. Otherwise it holds.
- R6: The wrap flag is set by every tick that moves the counter from 1 to 0. It stays set until a control/status read, and it is cleared on the clock edge that ends that read. The read itself returns the flag as it was before clearing. A set and a clear in the same cycle leave the flag set.
- R7: When interrupt enable is 1, `tick_irq` is high for exactly the one cycle after the edge that moved the counter from 1 to 0. When interrupt enable is 0, `tick_irq` stays low.
- R8: A write of any data to the current-count register clears the counter and the wrap flag. This takes priority over a tick in the same cycle.
- R9: With a reload value of 0, the enabled counter stays at 0, never sets the wrap flag and never raises `tick_irq`.
- R10: While run enable is 0, the counter holds its value.
- R11: Only control bits 0 to 2 are writable. Write data in bit 16 or in any other bit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| ref_tick | input | 1 | External reference tick enable |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bench measures the exact interrupt spacing for reloads of 5 and 1. An off-by-one in the reload path or a decrement that skips zero would shift the pulse positions. Reload 0 must never pulse, and a design that wraps through the all-ones pattern would. The bench reads the wrap flag back to back and reads the counter while it is disabled. A design that left the flag sticky, or let a disabled counter drift, would show a wrong value. It also writes the current-count register mid-count with all-ones data and writes the read-only flag bit. A design that stored that data or failed to clear the flag would read back nonzero.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;

  localparam logic [31:0] OFS_CTRL   = 32'h10;
  localparam logic [31:0] OFS_RELOAD = 32'h14;
  localparam logic [31:0] OFS_CURR   = 32'h18;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_SRC  = 2;
  localparam int CTRL_WRAP = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CURR
  } reg_sel_e;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tick_decode.sv
module tick_decode
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_reload,
  output logic              wr_curr,
  output logic              rd_ctrl
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_CTRL   = OFS_CTRL[ADDR_W-1:2];
  localparam logic [WA_W-1:0] WA_RELOAD = OFS_RELOAD[ADDR_W-1:2];
  localparam logic [WA_W-1:0] WA_CURR   = OFS_CURR[ADDR_W-1:2];

  logic [WA_W-1:0] word_addr;
  logic            unused_byte_lanes;

  assign word_addr         = bus_addr[ADDR_W-1:2];
  assign unused_byte_lanes = ^bus_addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    if      (word_addr == WA_CTRL)   sel = SEL_CTRL;
    else if (word_addr == WA_RELOAD) sel = SEL_RELOAD;
    else if (word_addr == WA_CURR)   sel = SEL_CURR;
  end

  assign wr_ctrl   = bus_req &  bus_we & (sel == SEL_CTRL);
  assign wr_reload = bus_req &  bus_we & (sel == SEL_RELOAD);
  assign wr_curr   = bus_req &  bus_we & (sel == SEL_CURR);
  assign rd_ctrl   = bus_req & ~bus_we & (sel == SEL_CTRL);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic             run_en,
  output logic             irq_en,
  output logic             src_core,
  output logic [CNT_W-1:0] reload
);
  logic             run_d, ie_d, src_d;
  logic [CNT_W-1:0] reload_d;

  always_comb begin
    run_d    = run_en;
    ie_d     = irq_en;
    src_d    = src_core;
    reload_d = reload;
    if (wr_ctrl) begin
      run_d = wdata[CTRL_RUN];
      ie_d  = wdata[CTRL_IE];
      src_d = wdata[CTRL_SRC];
    end
    if (wr_reload) reload_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      irq_en   <= 1'b0;
      src_core <= 1'b0;
      reload   <= '0;
    end else begin
      run_en   <= run_d;
      irq_en   <= ie_d;
      src_core <= src_d;
      reload   <= reload_d;
    end
  end
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             irq_en,
  input  logic             src_core,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] reload,
  input  logic             wr_curr,
  input  logic             rd_ctrl,
  output logic [CNT_W-1:0] count,
  output logic             wrap_flag,
  output logic             irq
);
  logic             tick_en, at_one, at_zero;
  logic [CNT_W-1:0] count_d;
  logic             flag_d, irq_d;

  assign tick_en = run_en & (src_core | ref_tick);
  assign at_one  = (count == CNT_W'(1));
  assign at_zero = (count == '0);

  always_comb begin
    count_d = count;
    flag_d  = wrap_flag;
    irq_d   = 1'b0;
    if (rd_ctrl) flag_d = 1'b0;
    if (wr_curr) begin
      count_d = '0;
      flag_d  = 1'b0;
    end else if (tick_en) begin
      if (at_zero) count_d = reload;
      else         count_d = count - CNT_W'(1);
      if (at_one) begin
        flag_d = 1'b1;
        irq_d  = irq_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      wrap_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      count     <= count_d;
      wrap_flag <= flag_d;
      irq       <= irq_d;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic              tick_irq
);
  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             wr_ctrl, wr_reload, wr_curr, rd_ctrl;
  logic             run_en, irq_en, src_core;
  logic [CNT_W-1:0] reload, count;
  logic             wrap_flag;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  tick_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tick_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .sel       (sel),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload),
    .wr_curr   (wr_curr),
    .rd_ctrl   (rd_ctrl)
  );

  tick_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload),
    .wdata     (bus_wdata[CNT_W-1:0]),
    .run_en    (run_en),
    .irq_en    (irq_en),
    .src_core  (src_core),
    .reload    (reload)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (run_en),
    .irq_en    (irq_en),
    .src_core  (src_core),
    .ref_tick  (ref_tick),
    .reload    (reload),
    .wr_curr   (wr_curr),
    .rd_ctrl   (rd_ctrl),
    .count     (count),
    .wrap_flag (wrap_flag),
    .irq       (tick_irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        bus_rdata[CTRL_RUN]  = run_en;
        bus_rdata[CTRL_IE]   = irq_en;
        bus_rdata[CTRL_SRC]  = src_core;
        bus_rdata[CTRL_WRAP] = wrap_flag;
      end
      SEL_RELOAD: bus_rdata = DATA_W'(reload);
      SEL_CURR:   bus_rdata = DATA_W'(count);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tick_irq,
  input logic              irq_en,
  input logic              run_en,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              wrap_flag,
  input logic              wr_curr,
  input logic              rd_ctrl
);
  logic wide_sel;
  assign wide_sel = bus_req && !bus_we &&
                    (bus_addr[ADDR_W-1:2] == OFS_RELOAD[ADDR_W-1:2] ||
                     bus_addr[ADDR_W-1:2] == OFS_CURR[ADDR_W-1:2]);

  // R7
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_irq |=> !tick_irq);

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_irq |-> $past(irq_en));

  // R8
  curr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_curr |=> (count == '0 && !wrap_flag));

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wide_sel |-> ((bus_rdata >> CNT_W) == 32'd0));

  // R9
  zero_reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count == '0 && reload == '0) |=> (count == '0 && !tick_irq));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wrap_flag && !rd_ctrl && !wr_curr) |=> wrap_flag);

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_en && !wr_curr) |=> $stable(count));
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .tick_irq   (tick_irq),
  .irq_en     (irq_en),
  .run_en     (run_en),
  .count      (count),
  .reload     (reload),
  .wrap_flag  (wrap_flag),
  .wr_curr    (wr_curr),
  .rd_ctrl    (rd_ctrl)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_RLD  = 8'h14;
  localparam logic [7:0] A_CUR  = 8'h18;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  // write then read back, counter disabled throughout
  localparam vec_t VECS [NV] = '{
    '{8'h14, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R3 upper bits dropped
    '{8'h14, 32'h0012_3456, 32'h0012_3456},  // R2 reload offset
    '{8'h10, 32'hFFFF_FFF8, 32'h0000_0000},  // R11 only bits 0..2 writable
    '{8'h10, 32'h0001_0006, 32'h0000_0006},  // R11 flag bit not writable
    '{8'h18, 32'h00AB_CDEF, 32'h0000_0000},  // R8 data ignored, clears
    '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 unmapped offset
    '{8'h14, 32'h0000_0000, 32'h0000_0000}   // R2 reload cleared
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              ref_tick, tick_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer #(.ADDR_W(ADDR_W), .CNT_W(24)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ref_tick  (ref_tick),
    .tick_irq  (tick_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic ref_pulse();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    #1;
  endtask

  task automatic setup(input logic [31:0] rld, input logic [31:0] ctl);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CUR, 32'h0);
    bus_write(A_RLD, rld);
    bus_write(A_CTRL, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
    bus_read(A_RLD, rd);  check("R1 reload", rd, 32'h0);
    bus_read(A_CUR, rd);  check("R1 count", rd, 32'h0);
    check("R1 irq", {31'b0, tick_irq}, 32'h0);

    // register table: R2 R3 R8 R11
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].addr, VECS[i].wdata);
      bus_read(VECS[i].addr, rd);
      check("R2 R3 R8 R11 table", rd, VECS[i].exp);
    end

    // R4 R7 core clock, reload 5: irq every 6 cycles
    setup(32'd5, 32'h7);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk); #1;
      check("R4 R7 irq spacing reload 5", {31'b0, tick_irq}, {31'b0, (k % 6) == 0});
    end
    bus_write(A_CTRL, 32'h2);
    bus_read(A_CTRL, rd); check("R6 flag set", rd, 32'h0001_0002);
    bus_read(A_CTRL, rd); check("R6 flag cleared by read", rd, 32'h0000_0002);
    bus_read(A_CUR, rd);  check("R10 count held", rd, 32'd4);
    repeat (5) @(negedge clk);
    bus_read(A_CUR, rd);  check("R10 count still held", rd, 32'd4);

    // R4 reload 1: irq every 2 cycles
    setup(32'd1, 32'h7);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); #1;
      check("R4 irq spacing reload 1", {31'b0, tick_irq}, {31'b0, (k % 2) == 0});
    end

    // R5 R7 reference tick source
    setup(32'd3, 32'h3);
    repeat (10) @(negedge clk);
    bus_read(A_CUR, rd); check("R5 no ref no tick", rd, 32'h0);
    ref_pulse();
    ref_pulse();
    bus_read(A_CUR, rd); check("R5 count after two ref ticks", rd, 32'd2);
    ref_pulse();
    check("R7 irq low before wrap", {31'b0, tick_irq}, 32'h0);
    ref_pulse();
    check("R7 irq on wrap", {31'b0, tick_irq}, 32'h1);
    @(negedge clk); #1;
    check("R7 irq one cycle", {31'b0, tick_irq}, 32'h0);
    bus_read(A_CUR, rd);  check("R5 count zero", rd, 32'h0);
    bus_read(A_CTRL, rd); check("R6 flag on ref wrap", rd, 32'h0001_0003);

    // R7 interrupt disabled: flag but no irq
    setup(32'd3, 32'h1);
    for (int p = 0; p < 4; p++) begin
      ref_pulse();
      check("R7 no irq when disabled", {31'b0, tick_irq}, 32'h0);
    end
    bus_read(A_CTRL, rd); check("R6 flag without irq", rd, 32'h0001_0001);

    // R8 current-count write mid-count
    setup(32'd2, 32'h5);
    repeat (2) @(negedge clk);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CUR, rd);  check("R8 count before clear", rd, 32'd2);
    bus_write(A_CUR, 32'hFFFF_FFFF);
    bus_read(A_CUR, rd);  check("R8 count cleared", rd, 32'h0);
    bus_read(A_CTRL, rd); check("R8 flag cleared", rd, 32'h0);

    // R9 reload zero
    setup(32'd0, 32'h7);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk); #1;
      check("R9 no irq at reload 0", {31'b0, tick_irq}, 32'h0);
    end
    bus_read(A_CUR, rd);  check("R9 count stays 0", rd, 32'h0);
    bus_read(A_CTRL, rd); check("R9 no flag", rd, 32'h7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule